// File: doc/BRIEF.md
# Run-time configurable CRC engine with residue check

This block computes a cyclic redundancy checksum over a stream of bytes, one byte per clock. Each cycle it folds a whole byte into a shift-register remainder using modulo-2 division, where the polynomial is XORed in only when the bit leaving the top of the register differs from the incoming message bit. The register is used in the direct form, so the result matches division of the message followed by as many zero bits as the polynomial degree, with no padding cycles. A frame is marked by a start flag on its first byte and an end flag on its last. The checksum appears one cycle after the last byte is taken.

The polynomial, the starting value, the final XOR constant, the checksum width (16 or 32 bits), bit reversal of each input byte and bit reversal of the finished word are all configuration inputs. One engine can therefore produce the common reflected 32-bit checksum and the plain 16-bit checksum. The configuration must stay stable from the first byte of a frame to its last.

In check mode a receiver runs a whole frame through the engine, data and appended checksum together. The engine compares the remainder, after optional output reversal but before the final XOR, with a residue constant from configuration, and raises a pass or fail flag. With a zero seed, no XOR and no reversal, an error-free frame leaves zero. With the reflected 32-bit setting it leaves a fixed nonzero constant.

Top module: `crc_engine`

## Requirements
- R1: With cfg_wide=1, polynomial 0x04C11DB7, seed 0xFFFFFFFF, final XOR 0xFFFFFFFF and both reversals on, the ASCII bytes "123456789" give out_crc 0xCBF43926.
- R2: With cfg_wide=0, polynomial 0x1021, seed 0xFFFF, final XOR 0 and both reversals off, the ASCII bytes "123456789" give out_crc 0x29B1.
- R3: With cfg_wide=0 only bits 15:0 of polynomial, seed, final XOR and residue take part, and the register's top bit is bit 15. The result sits in out_crc[15:0] and out_crc[31:16] is zero.
- R4: With cfg_refin=1 each byte is bit-reversed before it enters, so bit 0 of the byte is divided first. With cfg_refin=0 bit 7 goes first.
- R5: out_crc is the final register bit-reversed over the active width when cfg_refout=1, or taken as is when it is 0, and then XORed with the final XOR constant.
- R6: A byte taken with in_sof=1 is folded into the seed instead of the running register, so a byte carrying both in_sof and in_eof is a complete one-byte frame.
- R7: out_valid is high for exactly the one cycle after a byte with in_eof=1 is taken, and otherwise low. out_crc holds its value until the next result. Frames may follow each other with no idle cycle.
- R8: A cycle with in_valid=0 leaves the register unchanged whatever in_data, in_sof and in_eof carry, so idle gaps inside a frame do not change the result.
- R9: When out_valid is high and cfg_check was 1 at the last byte, out_pass is 1 if the register view (reversed when cfg_refout=1, with no final XOR) equals cfg_residue, and otherwise out_fail is 1. Both flags are 0 in every other cycle. The plain 16-bit setting with the checksum appended high byte first leaves residue 0. The reflected 32-bit setting with the checksum appended low byte first leaves 0xDEBB20E3.
- R10: During reset in_ready and out_valid are 0. From the first clock edge after reset is released, in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 selects the 32-bit width, 0 the 16-bit width |
| cfg_poly | input | 32 | Polynomial in normal form, top term left out |
| cfg_seed | input | 32 | Register value at frame start |
| cfg_xorout | input | 32 | Constant XORed onto the result |
| cfg_refin | input | 1 | Bit-reverse each input byte |
| cfg_refout | input | 1 | Bit-reverse the finished word |
| cfg_check | input | 1 | Enable residue comparison |
| cfg_residue | input | 32 | Expected remainder of an error-free frame |
| in_valid | input | 1 | Byte present |
| in_ready | output | 1 | Engine can take a byte |
| in_data | input | 8 | Message byte |
| in_sof | input | 1 | Byte is the first of its frame |
| in_eof | input | 1 | Byte is the last of its frame |
| out_valid | output | 1 | One-cycle result strobe |
| out_crc | output | 32 | Checksum, held between results |
| out_pass | output | 1 | Residue matched |
| out_fail | output | 1 | Residue did not match |

## Verification
Two things can fall in the same cycle. One is the seed load and the finish of a frame, when a one-byte frame carries in_sof and in_eof together. The other is one frame's result strobe and the first byte of the next frame, when frames run back to back. The bench sends directed one-byte frames in both widths and mixes frames with no gap between them into constrained-random traffic with random idle cycles inside frames. A monitor judges each strobe by its cycle, one after the accepted end byte, and by checksum and flags against a bench model, so a seed that leaks into the next frame or a result that is late or missing is reported.

// File: rtl/crc_pkg.sv
package crc_pkg;

   localparam int unsigned CRC_MAX_W    = 32;
   localparam int unsigned CRC_NARROW_W = 16;
   localparam int unsigned CRC_BYTE_W   = 8;

   typedef enum logic {
      CRC_SEL_NARROW = 1'b0,
      CRC_SEL_WIDE   = 1'b1
   } crc_width_e;

endpackage

// File: rtl/crc_bitrev.sv
module crc_bitrev #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   for (genvar i = 0; i < W; i++) begin : g_swap
      assign dout[i] = din[W-1-i];
   end

endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
   parameter int unsigned CW = 32,
   parameter int unsigned NW = 16,
   parameter int unsigned DW = 8
) (
   input  logic [CW-1:0] cur,
   input  logic [DW-1:0] din,
   input  logic [CW-1:0] poly,
   input  logic [CW-1:0] mask,
   input  crc_pkg::crc_width_e wsel,
   output logic [CW-1:0] nxt
);

   logic [CW-1:0] stage [0:DW];

   assign stage[0] = cur;

   for (genvar k = 0; k < DW; k++) begin : g_bit
      logic          top_bit;
      logic          feedback;
      logic [CW-1:0] shifted;

      assign top_bit  = (wsel == crc_pkg::CRC_SEL_WIDE) ? stage[k][CW-1] : stage[k][NW-1];
      assign feedback = top_bit ^ din[DW-1-k];
      assign shifted  = {stage[k][CW-2:0], 1'b0} & mask;
      assign stage[k+1] = feedback ? (shifted ^ poly) : shifted;
   end

   assign nxt = stage[DW];

endmodule

// File: rtl/crc_finalize.sv
module crc_finalize #(
   parameter int unsigned CW = 32,
   parameter int unsigned NW = 16
) (
   input  logic [CW-1:0] raw,
   input  logic [CW-1:0] xorout,
   input  logic [CW-1:0] mask,
   input  crc_pkg::crc_width_e wsel,
   input  logic          refout,
   output logic [CW-1:0] view,
   output logic [CW-1:0] result
);

   logic [CW-1:0] rev_full;
   logic [NW-1:0] rev_narrow;

   crc_bitrev #(.W(CW)) u_rev_full (
      .din  (raw),
      .dout (rev_full)
   );

   crc_bitrev #(.W(NW)) u_rev_narrow (
      .din  (raw[NW-1:0]),
      .dout (rev_narrow)
   );

   always_comb begin
      if (!refout) begin
         view = raw;
      end else if (wsel == crc_pkg::CRC_SEL_WIDE) begin
         view = rev_full;
      end else begin
         view = {{(CW-NW){1'b0}}, rev_narrow};
      end
      result = view ^ (xorout & mask);
   end

endmodule

// File: rtl/crc_engine.sv
module crc_engine #(
   parameter int unsigned CRC_W    = crc_pkg::CRC_MAX_W,
   parameter int unsigned NARROW_W = crc_pkg::CRC_NARROW_W,
   parameter int unsigned DATA_W   = crc_pkg::CRC_BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wide,
   input  logic [CRC_W-1:0]  cfg_poly,
   input  logic [CRC_W-1:0]  cfg_seed,
   input  logic [CRC_W-1:0]  cfg_xorout,
   input  logic              cfg_refin,
   input  logic              cfg_refout,
   input  logic              cfg_check,
   input  logic [CRC_W-1:0]  cfg_residue,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sof,
   input  logic              in_eof,
   output logic              out_valid,
   output logic [CRC_W-1:0]  out_crc,
   output logic              out_pass,
   output logic              out_fail
);

   localparam int unsigned UPPER_W = CRC_W - NARROW_W;
   localparam logic [CRC_W-1:0] NARROW_MASK = {{UPPER_W{1'b0}}, {NARROW_W{1'b1}}};
   localparam logic [CRC_W-1:0] WIDE_MASK   = {CRC_W{1'b1}};

   crc_pkg::crc_width_e wsel;
   logic [CRC_W-1:0]  width_mask;
   logic [DATA_W-1:0] byte_rev;
   logic [DATA_W-1:0] byte_in;
   logic [CRC_W-1:0]  crc_q;
   logic [CRC_W-1:0]  step_cur;
   logic [CRC_W-1:0]  step_nxt;
   logic [CRC_W-1:0]  fin_view;
   logic [CRC_W-1:0]  fin_result;
   logic              ready_q;
   logic              accept;
   logic              residue_hit;

   assign wsel       = crc_pkg::crc_width_e'(cfg_wide);
   assign width_mask = (wsel == crc_pkg::CRC_SEL_WIDE) ? WIDE_MASK : NARROW_MASK;
   assign in_ready   = ready_q;
   assign accept     = in_valid & ready_q;

   crc_bitrev #(.W(DATA_W)) u_in_rev (
      .din  (in_data),
      .dout (byte_rev)
   );

   assign byte_in  = cfg_refin ? byte_rev : in_data;
   assign step_cur = in_sof ? (cfg_seed & width_mask) : crc_q;

   crc_byte_step #(.CW(CRC_W), .NW(NARROW_W), .DW(DATA_W)) u_step (
      .cur  (step_cur),
      .din  (byte_in),
      .poly (cfg_poly & width_mask),
      .mask (width_mask),
      .wsel (wsel),
      .nxt  (step_nxt)
   );

   crc_finalize #(.CW(CRC_W), .NW(NARROW_W)) u_fin (
      .raw    (step_nxt),
      .xorout (cfg_xorout),
      .mask   (width_mask),
      .wsel   (wsel),
      .refout (cfg_refout),
      .view   (fin_view),
      .result (fin_result)
   );

   assign residue_hit = (fin_view == (cfg_residue & width_mask));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q   <= 1'b0;
         crc_q     <= '0;
         out_valid <= 1'b0;
         out_crc   <= '0;
         out_pass  <= 1'b0;
         out_fail  <= 1'b0;
      end else begin
         ready_q   <= 1'b1;
         out_valid <= accept & in_eof;
         if (accept) begin
            crc_q <= step_nxt;
         end
         if (accept && in_eof) begin
            out_crc  <= fin_result;
            out_pass <= cfg_check & residue_hit;
            out_fail <= cfg_check & ~residue_hit;
         end else begin
            out_pass <= 1'b0;
            out_fail <= 1'b0;
         end
      end
   end

   // R7: the strobe follows an accepted end byte, and only that
   a_r7_strobe_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_eof) |=> out_valid);
   a_r7_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(accept && in_eof));

   // R8: an idle cycle leaves the running register alone
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(crc_q));

   // R9: flags only with the strobe, never both at once
   a_r9_flags_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_pass && !out_fail));
   a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_pass && out_fail));

   // R3: narrow results leave the upper half clear
   a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_eof && !cfg_wide) |=> (out_crc[CRC_W-1:NARROW_W] == '0));

endmodule

// File: tb/crc_engine_test.sv
module crc_engine_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wide;
   logic [31:0] cfg_poly, cfg_seed, cfg_xorout, cfg_residue;
   logic        cfg_refin, cfg_refout, cfg_check;
   logic        in_valid;
   logic        in_ready;
   logic [7:0]  in_data;
   logic        in_sof, in_eof;
   logic        out_valid;
   logic [31:0] out_crc;
   logic        out_pass, out_fail;

   always #5 clk = ~clk;

   crc_engine uut (
      .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_poly(cfg_poly),
      .cfg_seed(cfg_seed), .cfg_xorout(cfg_xorout), .cfg_refin(cfg_refin),
      .cfg_refout(cfg_refout), .cfg_check(cfg_check), .cfg_residue(cfg_residue),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_sof(in_sof), .in_eof(in_eof), .out_valid(out_valid),
      .out_crc(out_crc), .out_pass(out_pass), .out_fail(out_fail)
   );

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   logic [7:0]  msg [0:63];
   logic [31:0] q_crc  [0:255];
   bit          q_chk  [0:255];
   bit          q_pass [0:255];
   string       q_tag  [0:255];
   int          q_wr = 0;
   int          q_rd = 0;
   bit          pend = 0;
   bit          mon_en = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] wmask(input bit wide);
      return wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
   endfunction

   function automatic logic [7:0] rev8(input logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return r;
   endfunction

   // remainder after n bytes of msg, bit-serial division
   function automatic logic [31:0] mdl_reg(input bit wide, input logic [31:0] poly,
                                           input logic [31:0] seed, input bit refin,
                                           input int n);
      logic [31:0] r;
      logic [7:0]  b;
      logic        top;
      r = seed & wmask(wide);
      for (int i = 0; i < n; i++) begin
         b = refin ? rev8(msg[i]) : msg[i];
         for (int k = 7; k >= 0; k--) begin
            top = wide ? r[31] : r[15];
            r = (r << 1) & wmask(wide);
            if (top ^ b[k]) r = r ^ (poly & wmask(wide));
         end
      end
      return r;
   endfunction

   function automatic logic [31:0] mdl_view(input bit wide, input bit refout,
                                            input logic [31:0] r);
      logic [31:0] v;
      int w;
      w = wide ? 32 : 16;
      if (!refout) return r;
      v = '0;
      for (int i = 0; i < w; i++) v[i] = r[w-1-i];
      return v;
   endfunction

   // monitor: strobe timing and results
   always @(posedge clk) begin
      if (rst_n) pend <= in_valid && in_ready && in_eof;
      else       pend <= 1'b0;
   end

   always @(negedge clk) begin
      if (rst_n && mon_en) begin
         if (out_valid !== pend)
            check(0, "R7 strobe timing", {31'd0, out_valid}, {31'd0, pend});
         if (out_valid) begin
            if (q_rd == q_wr) begin
               check(0, "R7 unexpected strobe", 32'd1, 32'd0);
            end else begin
               check(out_crc === q_crc[q_rd % 256], q_tag[q_rd % 256], out_crc,
                     q_crc[q_rd % 256]);
               check(out_pass === (q_chk[q_rd % 256] && q_pass[q_rd % 256]),
                     "R9 pass flag", {31'd0, out_pass},
                     {31'd0, q_chk[q_rd % 256] && q_pass[q_rd % 256]});
               check(out_fail === (q_chk[q_rd % 256] && !q_pass[q_rd % 256]),
                     "R9 fail flag", {31'd0, out_fail},
                     {31'd0, q_chk[q_rd % 256] && !q_pass[q_rd % 256]});
               q_rd++;
            end
         end else begin
            if (out_pass || out_fail)
               check(0, "R9 flag without strobe", {30'd0, out_pass, out_fail}, 32'd0);
         end
      end
   end

   task automatic push_exp(input logic [31:0] crc, input bit chk, input bit pass,
                           input string tag);
      q_crc[q_wr % 256]  = crc;
      q_chk[q_wr % 256]  = chk;
      q_pass[q_wr % 256] = pass;
      q_tag[q_wr % 256]  = tag;
      q_wr++;
   endtask

   task automatic set_cfg(input bit wide, input logic [31:0] poly, input logic [31:0] seed,
                          input logic [31:0] xo, input bit ri, input bit ro,
                          input bit chk, input logic [31:0] res);
      cfg_wide = wide; cfg_poly = poly; cfg_seed = seed; cfg_xorout = xo;
      cfg_refin = ri; cfg_refout = ro; cfg_check = chk; cfg_residue = res;
   endtask

   // expected result of the current config over msg[0:n-1]
   function automatic logic [31:0] exp_crc(input int n);
      return mdl_view(cfg_wide, cfg_refout,
                      mdl_reg(cfg_wide, cfg_poly, cfg_seed, cfg_refin, n))
             ^ (cfg_xorout & wmask(cfg_wide));
   endfunction

   // drive msg[0:n-1]; called just after a falling edge
   task automatic send(input int n, input int max_gap);
      int g;
      for (int i = 0; i < n; i++) begin
         g = (max_gap > 0) ? int'($urandom % (max_gap + 1)) : 0;
         for (int j = 0; j < g; j++) begin
            in_valid = 1'b0;
            in_data  = 8'($urandom);
            in_sof   = 1'($urandom);
            in_eof   = 1'($urandom);
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_data  = msg[i];
         in_sof   = (i == 0);
         in_eof   = (i == n - 1);
         @(negedge clk);
      end
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_eof   = 1'b0;
   endtask

   task automatic load_digits();
      for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
   endtask

   task automatic drain();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      int dummy;
      logic [31:0] c, r, res;
      int n;
      bit wide, ok;
      dummy = $urandom(32'h00C0_FFEE);
      rst_n = 1'b0;
      in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0;
      set_cfg(1, 32'h04C1_1DB7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 0, 0);
      repeat (4) @(negedge clk);
      // R10 reset state
      check(in_ready === 1'b0, "R10 ready in reset", {31'd0, in_ready}, 32'd0);
      check(out_valid === 1'b0, "R10 strobe in reset", {31'd0, out_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready === 1'b1, "R10 ready after reset", {31'd0, in_ready}, 32'd1);
      mon_en = 1;

      // R1 golden reflected 32-bit
      load_digits();
      check(exp_crc(9) == 32'hCBF4_3926, "R1 bench model", exp_crc(9), 32'hCBF4_3926);
      push_exp(32'hCBF4_3926, 0, 0, "R1 golden 32-bit");
      send(9, 0);
      drain();

      // R2 and R3 golden 16-bit, upper config bits set to junk
      set_cfg(0, 32'hABCD_1021, 32'h5555_FFFF, 32'h9999_0000, 0, 0, 0, 0);
      push_exp(32'h0000_29B1, 0, 0, "R2 R3 golden 16-bit");
      send(9, 3);
      drain();

      // R6 one-byte frames in both widths, back to back
      msg[0] = 8'hA5;
      set_cfg(1, 32'h04C1_1DB7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 0, 0);
      push_exp(exp_crc(1), 0, 0, "R6 single byte wide");
      send(1, 0);
      set_cfg(0, 32'h0000_1021, 32'h0000_FFFF, 32'h0, 0, 0, 0, 0);
      push_exp(exp_crc(1), 0, 0, "R6 single byte narrow");
      send(1, 0);
      drain();

      // R9 plain 16-bit check: residue zero, then a corrupted copy
      for (int i = 0; i < 12; i++) msg[i] = 8'($urandom);
      set_cfg(0, 32'h0000_1021, 32'h0000_0000, 32'h0, 0, 0, 0, 0);
      c = exp_crc(12);
      msg[12] = c[15:8]; msg[13] = c[7:0];
      cfg_check = 1; cfg_residue = 32'h0;
      push_exp(exp_crc(14), 1, 1, "R9 clean 16-bit frame");
      send(14, 2);
      drain();
      msg[5] = msg[5] ^ 8'h10;
      push_exp(exp_crc(14), 1, 0, "R9 corrupted 16-bit frame");
      send(14, 0);
      drain();

      // R9 reflected 32-bit check: residue constant, then corrupted
      load_digits();
      set_cfg(1, 32'h04C1_1DB7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 0, 0);
      c = exp_crc(9);
      msg[9] = c[7:0]; msg[10] = c[15:8]; msg[11] = c[23:16]; msg[12] = c[31:24];
      cfg_check = 1; cfg_residue = 32'hDEBB_20E3;
      push_exp(exp_crc(13), 1, 1, "R9 clean 32-bit frame");
      send(13, 0);
      drain();
      msg[11] = msg[11] ^ 8'h01;
      push_exp(exp_crc(13), 1, 0, "R9 corrupted 32-bit frame");
      send(13, 1);
      drain();

      // R4 R5 R8: random configurations, gaps, back-to-back frames
      for (int f = 0; f < 60; f++) begin
         wide = 1'($urandom);
         n = 1 + int'($urandom % 24);
         for (int i = 0; i < n; i++) msg[i] = 8'($urandom);
         set_cfg(wide, $urandom, $urandom, $urandom, 1'($urandom), 1'($urandom),
                 1'($urandom), 0);
         r = mdl_view(cfg_wide, cfg_refout,
                      mdl_reg(cfg_wide, cfg_poly, cfg_seed, cfg_refin, n));
         res = $urandom[0] ? r : $urandom;
         cfg_residue = res;
         ok = (r == (res & wmask(wide)));
         push_exp(exp_crc(n), cfg_check, ok, "R4 R5 R8 random frame");
         send(n, (f % 3 == 0) ? 0 : 3);
         if (f % 4 == 0) drain();
      end
      drain();

      check(q_rd == q_wr, "R7 all results seen", q_rd, q_wr);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule